// File: doc/BRIEF.md
# Timer Capture/Compare Channel Pair

This block holds a free-running 16-bit up-counter and two general registers, A and B, that share it. Each general register is set by a 3-bit mode code. In one group of codes it is an output-compare register that drives a compare pin when the counter reaches its value. In the other group it is an input-capture register that stores the counter value when an edge arrives on a capture pin. A clear-enable bit for each register lets its match or capture reset the shared counter. That turns the pair into a period generator or a period-measurement unit.

Software reaches the block through a small register port. Writes are synchronous and reads are combinational. Address 0 is the 8-bit control register, addresses 1 and 2 are general registers A and B, and address 3 is the counter. An external mode-gating input turns every control-driven action off. While it is high, the control register can still be written but does nothing.

Top module: `tmr_cc_pair`

## Requirements
- R1: The control register resets to 0x00 and reads back what was written. Bits 2:0 hold the mode code of register A and bit 3 its clear-enable. Bits 6:4 hold the mode code of register B and bit 7 its clear-enable.
- R2: The counter resets to 0. It increments by one on each clock with `cnt_en_i` high, holds when `cnt_en_i` is low, and wraps from 0xFFFF to 0x0000. A bus write to it loads the written value.
- R3: Code 000, and every code with bit 2 set, drives the register's compare pin to 0 on the next clock, whatever the counter does.
- R4: A compare match is a clock where `cnt_en_i` is high and the counter equals the general register. On a match, code 001 drives the pin to 0 and code 010 drives it to 1, one clock later.
- R5: Code 011 inverts the pin on each compare match.
- R6: The capture pins pass through a two-flop synchroniser. Code 100 never captures. Code 101 stores the counter on a rising edge, code 110 on a falling edge, and code 111 on either edge. The stored value is the counter value in the clock where the synchronised edge is seen, which is two clocks after the pin changes.
- R7: When a register's clear-enable bit is 1, its compare match (codes 001 to 011) or its capture loads the counter with 0 on the next clock. This takes priority over the increment.
- R8: While `mode_gate_i` is 1, the compare pins hold their value, no capture takes place and the counter is not cleared. Control writes are still accepted.
- R9: Address 0 reads the control register zero-extended, addresses 1 and 2 read general registers A and B, and address 3 reads the counter. Each address is writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter clock enable |
| mode_gate_i | input | 1 | 1 suppresses all control-register actions |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data, combinational |
| cap_i | input | 2 | Capture pins, bit 0 for A and bit 1 for B |
| cmp_o | output | 2 | Compare pins, bit 0 for A and bit 1 for B |

## Verification
The set, clear and hold-zero codes are driven through counter sweeps that do and do not reach the register value, so a match that fires on the wrong count shows up as a pin change one clock early or late. A toggle run with clear-enable checks every clock against a modelled 0..3 sequence, which separates clear-over-increment priority from a plain wrap. The capture tests apply rising and falling pin edges under each of the four capture codes with a frozen counter, which shows exactly which edge each code reacts to. A live-counter capture pins down the two-clock synchroniser latency. Repeating the same patterns with the gate input high shows that pins, captures and clears are all held off.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
  typedef enum logic [2:0] {
    MD_OFF      = 3'd0,
    MD_CLR      = 3'd1,
    MD_SET      = 3'd2,
    MD_TGL      = 3'd3,
    MD_CAP_NONE = 3'd4,
    MD_CAP_RISE = 3'd5,
    MD_CAP_FALL = 3'd6,
    MD_CAP_BOTH = 3'd7
  } mode_e;

  typedef struct packed {
    logic  clr_en;
    mode_e mode;
  } fld_t;

  localparam int FLD_W  = $bits(fld_t);
  localparam int NUM_GR = 2;
  localparam int CTRL_W = FLD_W * NUM_GR;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_GRA  = 2'd1;
  localparam logic [1:0] ADDR_GRB  = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  // the last stage is only the previous value used to find the edge
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tmr_gr_unit.sv
module tmr_gr_unit
  import tmr_cc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         gate_i,
  input  fld_t         fld_i,
  input  logic [W-1:0] cnt_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rise_i,
  input  logic         fall_i,
  output logic [W-1:0] gr_o,
  output logic         pin_o,
  output logic         clr_req_o
);
  logic [W-1:0] gr_q;
  logic         pin_q;
  logic         match, cap_hit, cmp_hit, edge_ok;

  assign match = cnt_en_i && (cnt_i == gr_q);

  always_comb begin
    case (fld_i.mode)
      MD_CAP_RISE: edge_ok = rise_i;
      MD_CAP_FALL: edge_ok = fall_i;
      MD_CAP_BOTH: edge_ok = rise_i | fall_i;
      default:     edge_ok = 1'b0;
    endcase
  end

  assign cap_hit   = !gate_i && edge_ok;
  assign cmp_hit   = !gate_i && !fld_i.mode[2] && (fld_i.mode != MD_OFF) && match;
  assign clr_req_o = fld_i.clr_en && (cap_hit || cmp_hit);

  // capture beats a bus write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gr_q <= '0;
    else if (cap_hit) gr_q <= cnt_i;
    else if (wr_i)    gr_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else if (!gate_i) begin
      case (fld_i.mode)
        MD_CLR:  if (match) pin_q <= 1'b0;
        MD_SET:  if (match) pin_q <= 1'b1;
        MD_TGL:  if (match) pin_q <= ~pin_q;
        default: pin_q <= 1'b0;
      endcase
    end
  end

  assign gr_o  = gr_q;
  assign pin_o = pin_q;
endmodule

// File: rtl/tmr_cc_pair.sv
module tmr_cc_pair
  import tmr_cc_pkg::*;
#(
  parameter int W         = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         mode_gate_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   rd_addr_i,
  output logic [W-1:0] rd_data_o,
  input  logic [1:0]   cap_i,
  output logic [1:0]   cmp_o
);
  localparam int PAD_W = W - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      cnt_q;
  logic [W-1:0]      gr   [NUM_GR];
  logic [NUM_GR-1:0] clr_req, rise, fall, gr_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_CTRL) ctrl_q <= wr_data_i[CTRL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_CNT)  cnt_q <= wr_data_i;
    else if (|clr_req)                          cnt_q <= '0;
    else if (cnt_en_i)                          cnt_q <= cnt_q + 1'b1;
  end

  assign gr_wr[0] = wr_en_i && (wr_addr_i == ADDR_GRA);
  assign gr_wr[1] = wr_en_i && (wr_addr_i == ADDR_GRB);

  for (genvar i = 0; i < NUM_GR; i++) begin : g_gr
    tmr_sync_edge #(.STAGES(SYNC_STGS)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_i[i]),
      .rise_o (rise[i]),
      .fall_o (fall[i])
    );

    tmr_gr_unit #(.W(W)) u_unit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_en_i  (cnt_en_i),
      .gate_i    (mode_gate_i),
      .fld_i     (fld_t'(ctrl_q[i*FLD_W +: FLD_W])),
      .cnt_i     (cnt_q),
      .wr_i      (gr_wr[i]),
      .wr_data_i (wr_data_i),
      .rise_i    (rise[i]),
      .fall_i    (fall[i]),
      .gr_o      (gr[i]),
      .pin_o     (cmp_o[i]),
      .clr_req_o (clr_req[i])
    );
  end

  always_comb begin
    case (rd_addr_i)
      ADDR_CTRL: rd_data_o = {{PAD_W{1'b0}}, ctrl_q};
      ADDR_GRA:  rd_data_o = gr[0];
      ADDR_GRB:  rd_data_o = gr[1];
      default:   rd_data_o = cnt_q;
    endcase
  end
endmodule

// File: rtl/tmr_cc_pair_chk.sv
module tmr_cc_pair_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cnt_en_i,
  input logic         mode_gate_i,
  input logic         wr_en_i,
  input logic [1:0]   wr_addr_i,
  input logic [7:0]   ctrl,
  input logic [W-1:0] cnt,
  input logic [W-1:0] gr_a,
  input logic [1:0]   cmp_o
);
  logic cnt_wr, gra_wr, a_match;
  assign cnt_wr  = wr_en_i && wr_addr_i == 2'd3;
  assign gra_wr  = wr_en_i && wr_addr_i == 2'd1;
  assign a_match = cnt_en_i && cnt == gr_a;

  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i && !cnt_wr && cnt == {W{1'b1}} |=> cnt == '0);

  a_r3_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_gate_i && ctrl[2:0] == 3'd0 |=> !cmp_o[0]);

  a_r4_set_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_gate_i && ctrl[2:0] == 3'd2 && a_match |=> cmp_o[0]);

  a_r5_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_gate_i && ctrl[2:0] == 3'd3 && a_match |=> cmp_o[0] != $past(cmp_o[0]));

  a_r7_match_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_gate_i && ctrl[3] && ctrl[2:0] == 3'd2 && a_match && !cnt_wr |=> cnt == '0);

  a_r8_pins_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_gate_i |=> $stable(cmp_o));

  a_r8_gr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_gate_i && !gra_wr |=> $stable(gr_a));
endmodule

bind tmr_cc_pair tmr_cc_pair_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_en_i    (cnt_en_i),
  .mode_gate_i (mode_gate_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .ctrl        (ctrl_q),
  .cnt         (cnt_q),
  .gr_a        (gr[0]),
  .cmp_o       (cmp_o)
);

// File: tb/tb_tmr_cc_pair.sv
module tb_tmr_cc_pair;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, gate = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0, cap = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [1:0]  cmp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_cc_pair dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .mode_gate_i(gate),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cap_i(cap), .cmp_o(cmp)
  );

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(2'd0, v); chk("R1 ctrl reset", v, 16'h0000);
    rd(2'd3, v); chk("R2 cnt reset", v, 16'h0000);
    chk("R3 pins reset", {14'd0, cmp}, 16'h0000);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr(2'd0, 16'hFFA5); rd(2'd0, v); chk("R1 ctrl readback", v, 16'h00A5);
    wr(2'd1, 16'h1111); rd(2'd1, v); chk("R9 gra readback", v, 16'h1111);
    wr(2'd2, 16'h2222); rd(2'd2, v); chk("R9 grb readback", v, 16'h2222);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_count;
    logic [15:0] v;
    wr(2'd3, 16'hFFFE);
    cnt_en = 1'b1; tick(); rd(2'd3, v); chk("R2 increment", v, 16'hFFFF);
    tick(); rd(2'd3, v); chk("R2 wrap", v, 16'h0000);
    cnt_en = 1'b0; tick(3); rd(2'd3, v); chk("R2 hold", v, 16'h0000);
  endtask

  task automatic t_cmp;
    wr(2'd0, 16'h0002); wr(2'd1, 16'd5); wr(2'd3, 16'd0);
    cnt_en = 1'b1; tick(5);
    chk("R4 set before match", {15'd0, cmp[0]}, 16'd0);
    tick(); chk("R4 set on match", {15'd0, cmp[0]}, 16'd1);
    cnt_en = 1'b0;
    wr(2'd0, 16'h0001); wr(2'd3, 16'd4);
    chk("R4 clr holds before match", {15'd0, cmp[0]}, 16'd1);
    cnt_en = 1'b1; tick(2); cnt_en = 1'b0;
    chk("R4 clr on match", {15'd0, cmp[0]}, 16'd0);
    wr(2'd0, 16'h0002); wr(2'd3, 16'd4);
    cnt_en = 1'b1; tick(2); cnt_en = 1'b0;
    chk("R4 set again", {15'd0, cmp[0]}, 16'd1);
    wr(2'd0, 16'h0000); tick();
    chk("R3 code 000 forces low", {15'd0, cmp[0]}, 16'd0);
  endtask

  task automatic t_toggle;
    logic [15:0] v;
    int ec = 0;
    logic ep = 1'b0;
    wr(2'd0, 16'h000B); wr(2'd1, 16'd3); wr(2'd3, 16'd0);
    cnt_en = 1'b1;
    for (int k = 0; k < 16; k++) begin
      if (ec == 3) begin ec = 0; ep = ~ep; end else ec++;
      tick(); rd(2'd3, v);
      chk("R7 clear over increment", v, 16'(ec));
      chk("R5 toggle", {15'd0, cmp[0]}, {15'd0, ep});
    end
    cnt_en = 1'b0;
  endtask

  task automatic cap_edge(logic val);
    cap[1] = val; tick(3);
  endtask

  task automatic t_capture;
    logic [15:0] v, c0;
    wr(2'd0, 16'h0050); wr(2'd3, 16'h1234);
    cap_edge(1'b1); rd(2'd2, v); chk("R6 rise code 101", v, 16'h1234);
    wr(2'd3, 16'h2000);
    cap_edge(1'b0); rd(2'd2, v); chk("R6 fall ignored by 101", v, 16'h1234);
    wr(2'd0, 16'h0060); wr(2'd3, 16'h3000);
    cap_edge(1'b1); rd(2'd2, v); chk("R6 rise ignored by 110", v, 16'h1234);
    cap_edge(1'b0); rd(2'd2, v); chk("R6 fall code 110", v, 16'h3000);
    wr(2'd0, 16'h0070); wr(2'd3, 16'h4000);
    cap_edge(1'b1); rd(2'd2, v); chk("R6 rise code 111", v, 16'h4000);
    wr(2'd3, 16'h4100);
    cap_edge(1'b0); rd(2'd2, v); chk("R6 fall code 111", v, 16'h4100);
    wr(2'd0, 16'h0040); wr(2'd3, 16'h5000);
    cap_edge(1'b1); rd(2'd2, v); chk("R6 code 100 no capture", v, 16'h4100);
    cap_edge(1'b0);
    wr(2'd0, 16'h00D0); wr(2'd3, 16'h0100);
    cnt_en = 1'b1;
    rd(2'd3, c0); cap[1] = 1'b1;
    tick(3);
    rd(2'd2, v); chk("R6 live capture latency", v, c0 + 16'd2);
    rd(2'd3, v); chk("R7 capture clears counter", v, 16'h0000);
    cnt_en = 1'b0;
  endtask

  task automatic t_gate;
    logic [15:0] v, grb;
    rd(2'd2, grb);
    gate = 1'b1;
    wr(2'd0, 16'h000A); wr(2'd1, 16'd2); wr(2'd3, 16'd0);
    cnt_en = 1'b1; tick(5); cnt_en = 1'b0;
    rd(2'd3, v); chk("R8 no clear when gated", v, 16'd5);
    chk("R8 pin held when gated", {15'd0, cmp[0]}, 16'd0);
    wr(2'd0, 16'h00F0); rd(2'd0, v); chk("R8 ctrl writable when gated", v, 16'h00F0);
    wr(2'd3, 16'h7777);
    cap_edge(1'b0); rd(2'd2, v); chk("R8 no capture when gated", v, grb);
    rd(2'd3, v); chk("R8 cnt kept when gated", v, 16'h7777);
    gate = 1'b0;
    wr(2'd0, 16'h0020); wr(2'd2, 16'd3); wr(2'd3, 16'd0);
    cnt_en = 1'b1; tick(4); cnt_en = 1'b0;
    chk("R4 register B set", {14'd0, cmp}, 16'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_count();
    t_cmp();
    t_toggle();
    t_capture();
    t_gate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule